// File: doc/BRIEF.md
# Ratio-Switched System Clock Divider

This block turns one fast synthesis clock into the set of board clocks a host platform needs. The synthesis clock runs at twice the host rate. The block emits a complementary host pair, a complementary memory-reference pair at half the host rate, a group near 66 MHz and a group near 33 MHz. All of them are registered logic levels that a pad or clock-gating stage consumes. A common output-enable goes with them.

A three-bit select code picks the ratio family. When bit 2 is low the host runs near 100 MHz, so the 66 group divides the synthesis clock by 3 and the 33 group divides it by 6. When bit 2 is high the host runs near 133 MHz, so these dividers become 4 and 8. In both families the 66 group and the 33 group keep the same absolute frequency. Two codes are special. One releases the outputs to high impedance. The other is a crystal-bypass test mode: the synthesis clock input is fed from the crystal, and every output is a fixed power-of-two division of it. An active-low power-down input stops all clocks low.

All outputs come from one frame counter. A frame is the least common multiple of every active period, and every true-phase output is low in the last cycle of a frame. The select code and the power-down input are sampled only at that point, so a mode change or a stop never produces a shortened pulse.

Top module: `clk_ratio_gen`

## Requirements
- R1: While `rst` is high, every output including `clk_oe` and `xtal_bypass` is low at the next clock edge, and the select code is captured. The first edge after release starts a frame at phase 0.
- R2: While running, `host_clk` is high in even frame phases and low in odd ones, which is half the synthesis rate. `host_clk_b` is its exact complement.
- R3: While running, `mem_ref` is high in phases p with p mod 4 in {0,1}, which is a quarter of the synthesis rate. `mem_ref_b` is its exact complement.
- R4: With select bit 2 low (codes 000, 001, 010), `bus66` has a period of 3 synthesis cycles. It rises at the start of phases with p mod 3 = 0 and falls in the middle of the following cycle, giving a 50% duty cycle.
- R5: With select bit 2 low, `bus33` has a period of 6 synthesis cycles and is high in phases with p mod 6 in {1,2,3}.
- R6: With select bit 2 high, `bus66` is high in phases with p mod 4 in {0,1}, and `bus33` is high in phases with p mod 8 in {1,2,3,4}. Both change only on the rising edge.
- R7: Every rising edge of `bus33` comes exactly one synthesis cycle after a rising edge of `bus66`.
- R8: Code 011 drives `clk_oe` low and every clock output low.
- R9: Code 111 drives `xtal_bypass` high. The outputs follow the ratios of R6: host at clock/2, memory reference at clock/4, `bus66` at clock/4 and `bus33` at clock/8.
- R10: A frame lasts 12 cycles when the active code has bit 2 low and 8 cycles otherwise. `sel` is sampled only in the last cycle of a frame, in which `host_clk`, `mem_ref`, `bus66` and `bus33` are all low. A code held for a shorter time between two samples has no effect.
- R11: `pwr_dn_n` is sampled at the same frame boundary. If it is low there, every clock output stays low for the whole next frame while `clk_oe` keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Synthesis clock (twice host rate; crystal in bypass mode) |
| rst | input | 1 | Synchronous active-high reset |
| sel | input | 3 | Mode code; bit 2 picks the ratio family |
| pwr_dn_n | input | 1 | Active-low stop request |
| host_clk | output | N_HOST | Host clocks, true phase |
| host_clk_b | output | N_HOST | Host clocks, complement phase |
| mem_ref | output | 1 | Memory reference, true phase |
| mem_ref_b | output | 1 | Memory reference, complement phase |
| bus66 | output | N_66 | 66 MHz group |
| bus33 | output | N_33 | 33 MHz group |
| clk_oe | output | 1 | Output enable for all clocks |
| xtal_bypass | output | 1 | High while the crystal-bypass test code is active |

## Verification
The bench compares every output at both halves of each synthesis cycle. This exposes the mid-cycle fall of the odd-ratio 66 group, which a rising-edge-only sample would miss. It runs the slow family, the fast family, the bypass code and the high-impedance code back to back, changing the select mid-frame, so that the frame lengths of 12 and 8 and the late take-over of a new code are both visible. A power-down pulse shorter than a frame and a select glitch between boundaries show that neither input is sampled outside the boundary. A reset in the middle of a run shows that the code is captured at reset and that phase 0 restarts cleanly.

// File: rtl/clkgen_pkg.sv
`timescale 1ns/1ps
package clkgen_pkg;

  localparam logic [2:0] CODE_HIZ    = 3'b011;
  localparam logic [2:0] CODE_BYPASS = 3'b111;

  typedef struct packed {
    logic host;
    logic mref;
    logic g66;
    logic g33;
  } wave_t;

  function automatic int unsigned gcd_u(input int unsigned a, input int unsigned b);
    int unsigned x = a;
    int unsigned y = b;
    int unsigned t;
    while (y != 0) begin
      t = x % y;
      x = y;
      y = t;
    end
    return x;
  endfunction

  function automatic int unsigned lcm_u(input int unsigned a, input int unsigned b);
    return (a / gcd_u(a, b)) * b;
  endfunction

  // frame covers host (2), memory ref (4), 66 group (d) and 33 group (2d)
  function automatic int unsigned frame_len(input int unsigned d);
    return lcm_u(4, 2 * d);
  endfunction

  // rising-edge levels of every clock at frame phase k, 66 divider d
  function automatic wave_t wave_at(input int unsigned k, input int unsigned d);
    wave_t r;
    r.host = (k % 2) == 0;
    r.mref = (k % 4) < 2;
    r.g66  = (k % d) < (d / 2);
    r.g33  = ((k + 2 * d - 1) % (2 * d)) < d;
    return r;
  endfunction

endpackage

// File: rtl/clkgen_frame_ctl.sv
`timescale 1ns/1ps
module clkgen_frame_ctl
  import clkgen_pkg::*;
#(
  parameter int unsigned D_SLOW = 3,
  parameter int unsigned D_FAST = 4,
  parameter int unsigned PH_W   = 4
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [2:0]      sel,
  input  logic            pwr_dn_n,
  output logic [PH_W-1:0] ph_nx,
  output logic            slow_nx,
  output logic            live_nx,
  output logic            wrap,
  output logic            slow_q,
  output logic            live_q,
  output logic            oe_q,
  output logic            byp_q
);

  localparam int unsigned LEN_SLOW = frame_len(D_SLOW);
  localparam int unsigned LEN_FAST = frame_len(D_FAST);

  function automatic logic [PH_W-1:0] last_of(input logic [2:0] code);
    return code[2] ? PH_W'(LEN_FAST - 1) : PH_W'(LEN_SLOW - 1);
  endfunction

  logic [2:0]      act_q;
  logic [PH_W-1:0] ph_q;
  logic [2:0]      act_nx;
  logic            oe_nx;

  assign wrap    = (ph_q == last_of(act_q));
  assign act_nx  = wrap ? sel : act_q;
  assign ph_nx   = wrap ? '0 : ph_q + 1'b1;
  assign oe_nx   = wrap ? (sel != CODE_HIZ) : oe_q;
  assign live_nx = wrap ? (pwr_dn_n && (sel != CODE_HIZ)) : live_q;
  assign slow_nx = ~act_nx[2];
  assign slow_q  = ~act_q[2];

  always_ff @(posedge clk) begin
    if (rst) begin
      act_q  <= sel;
      ph_q   <= last_of(sel);
      live_q <= 1'b0;
      oe_q   <= 1'b0;
      byp_q  <= 1'b0;
    end else begin
      act_q  <= act_nx;
      ph_q   <= ph_nx;
      live_q <= live_nx;
      oe_q   <= oe_nx;
      byp_q  <= (act_nx == CODE_BYPASS);
    end
  end

  AST_PH_BOUND: assert property (@(posedge clk) disable iff (rst)
    ph_q <= last_of(act_q)); // R10

  AST_LIVE_NEEDS_OE: assert property (@(posedge clk) disable iff (rst)
    live_q |-> oe_q); // R8

endmodule

// File: rtl/clkgen_half_stretch.sv
`timescale 1ns/1ps
module clkgen_half_stretch (
  input  logic clk,
  input  logic rst,
  input  logic en,
  input  logic d,
  output logic q
);

  // falling-edge copy extends a rising-edge pulse by half a cycle
  always_ff @(negedge clk) begin
    if (rst) q <= 1'b0;
    else     q <= en & d;
  end

endmodule

// File: rtl/clkgen_wave_reg.sv
`timescale 1ns/1ps
module clkgen_wave_reg
  import clkgen_pkg::*;
#(
  parameter int unsigned D_SLOW = 3,
  parameter int unsigned D_FAST = 4,
  parameter int unsigned PH_W   = 4
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [PH_W-1:0] ph_nx,
  input  logic            slow_nx,
  input  logic            live_nx,
  input  logic            slow_q,
  input  logic            live_q,
  output logic            host,
  output logic            host_b,
  output logic            mref,
  output logic            mref_b,
  output logic            g66,
  output logic            g66_base,
  output logic            g33
);

  localparam logic ODD_SLOW = (D_SLOW % 2) == 1;
  localparam logic ODD_FAST = (D_FAST % 2) == 1;

  wave_t w_slow, w_fast, w_sel, w_gated;
  logic  stretch;

  always_comb begin
    w_slow  = wave_at(32'(ph_nx), D_SLOW);
    w_fast  = wave_at(32'(ph_nx), D_FAST);
    w_sel   = slow_nx ? w_slow : w_fast;
    w_gated = live_nx ? w_sel : '0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      host     <= 1'b0;
      host_b   <= 1'b0;
      mref     <= 1'b0;
      mref_b   <= 1'b0;
      g66_base <= 1'b0;
      g33      <= 1'b0;
    end else begin
      host     <= w_gated.host;
      host_b   <= live_nx & ~w_sel.host;
      mref     <= w_gated.mref;
      mref_b   <= live_nx & ~w_sel.mref;
      g66_base <= w_gated.g66;
      g33      <= w_gated.g33;
    end
  end

  generate
    if (ODD_SLOW || ODD_FAST) begin : g_odd
      clkgen_half_stretch u_stretch (
        .clk (clk),
        .rst (rst),
        .en  (slow_q ? ODD_SLOW : ODD_FAST),
        .d   (g66_base),
        .q   (stretch)
      );
    end else begin : g_even
      assign stretch = 1'b0;
    end
  endgenerate

  assign g66 = g66_base | stretch;

  AST_HOST_COMPL: assert property (@(posedge clk) disable iff (rst)
    live_q |-> (host_b == ~host)); // R2

  AST_MREF_COMPL: assert property (@(posedge clk) disable iff (rst)
    live_q |-> (mref_b == ~mref)); // R3

  AST_LEAD_66_33: assert property (@(posedge clk) disable iff (rst)
    $rose(g33) |-> $past(g66_base)); // R7

  AST_FAST_NO_STRETCH: assert property (@(posedge clk) disable iff (rst)
    (!slow_q && !ODD_FAST) |-> !stretch); // R6

endmodule

// File: rtl/clk_ratio_gen.sv
`timescale 1ns/1ps
module clk_ratio_gen
  import clkgen_pkg::*;
#(
  parameter int unsigned N_HOST = 4,
  parameter int unsigned N_66   = 4,
  parameter int unsigned N_33   = 10,
  parameter int unsigned D_SLOW = 3,
  parameter int unsigned D_FAST = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [2:0]        sel,
  input  logic              pwr_dn_n,
  output logic [N_HOST-1:0] host_clk,
  output logic [N_HOST-1:0] host_clk_b,
  output logic              mem_ref,
  output logic              mem_ref_b,
  output logic [N_66-1:0]   bus66,
  output logic [N_33-1:0]   bus33,
  output logic              clk_oe,
  output logic              xtal_bypass
);

  localparam int unsigned LEN_SLOW = frame_len(D_SLOW);
  localparam int unsigned LEN_FAST = frame_len(D_FAST);
  localparam int unsigned LEN_MAX  = (LEN_SLOW > LEN_FAST) ? LEN_SLOW : LEN_FAST;
  localparam int unsigned PH_W     = $clog2(LEN_MAX);

  logic [PH_W-1:0] ph_nx;
  logic slow_nx, live_nx, wrap, slow_q, live_q;
  logic host_w, host_b_w, mref_w, mref_b_w, g66_w, g66_base_w, g33_w;

  clkgen_frame_ctl #(.D_SLOW(D_SLOW), .D_FAST(D_FAST), .PH_W(PH_W)) u_ctl (
    .clk      (clk),
    .rst      (rst),
    .sel      (sel),
    .pwr_dn_n (pwr_dn_n),
    .ph_nx    (ph_nx),
    .slow_nx  (slow_nx),
    .live_nx  (live_nx),
    .wrap     (wrap),
    .slow_q   (slow_q),
    .live_q   (live_q),
    .oe_q     (clk_oe),
    .byp_q    (xtal_bypass)
  );

  clkgen_wave_reg #(.D_SLOW(D_SLOW), .D_FAST(D_FAST), .PH_W(PH_W)) u_wave (
    .clk      (clk),
    .rst      (rst),
    .ph_nx    (ph_nx),
    .slow_nx  (slow_nx),
    .live_nx  (live_nx),
    .slow_q   (slow_q),
    .live_q   (live_q),
    .host     (host_w),
    .host_b   (host_b_w),
    .mref     (mref_w),
    .mref_b   (mref_b_w),
    .g66      (g66_w),
    .g66_base (g66_base_w),
    .g33      (g33_w)
  );

  generate
    for (genvar i = 0; i < int'(N_HOST); i++) begin : g_host
      assign host_clk[i]   = host_w;
      assign host_clk_b[i] = host_b_w;
    end
    for (genvar i = 0; i < int'(N_66); i++) begin : g_b66
      assign bus66[i] = g66_w;
    end
    for (genvar i = 0; i < int'(N_33); i++) begin : g_b33
      assign bus33[i] = g33_w;
    end
  endgenerate

  assign mem_ref   = mref_w;
  assign mem_ref_b = mref_b_w;

  AST_FRAME_END_QUIET: assert property (@(posedge clk) disable iff (rst)
    wrap |-> !(host_w || mref_w || g66_base_w || g33_w)); // R10

  AST_OE_AT_FRAME: assert property (@(posedge clk) disable iff (rst)
    !wrap |=> $stable(clk_oe)); // R10

  AST_HIZ_QUIET: assert property (@(posedge clk) disable iff (rst)
    !clk_oe |-> !(host_w || host_b_w || mref_w || mref_b_w || g66_base_w || g33_w)); // R8

  AST_STOP_QUIET: assert property (@(posedge clk) disable iff (rst)
    !live_q |-> !(host_b_w || mref_b_w || g33_w)); // R11

endmodule

// File: tb/tb_clk_ratio_gen.sv
`timescale 1ns/1ps
module tb_clk_ratio_gen;

  localparam int NH = 4;
  localparam int N66 = 4;
  localparam int N33 = 10;
  localparam int VW = 2 + 2 * NH + 2 + N66 + N33;

  logic clk = 1'b1;
  logic rst = 1'b1;
  logic [2:0] sel = 3'b000;
  logic pwr_dn_n = 1'b1;
  logic [NH-1:0] host_clk, host_clk_b;
  logic mem_ref, mem_ref_b;
  logic [N66-1:0] bus66;
  logic [N33-1:0] bus33;
  logic clk_oe, xtal_bypass;

  always #2 clk = ~clk;

  clk_ratio_gen dut (
    .clk(clk), .rst(rst), .sel(sel), .pwr_dn_n(pwr_dn_n),
    .host_clk(host_clk), .host_clk_b(host_clk_b),
    .mem_ref(mem_ref), .mem_ref_b(mem_ref_b),
    .bus66(bus66), .bus33(bus33),
    .clk_oe(clk_oe), .xtal_bypass(xtal_bypass)
  );

  typedef struct {
    logic [VW-1:0] v;
    string tag;
  } item_t;

  item_t sb[$];
  int n_cmp = 0;
  int n_bad = 0;
  bit done = 0;

  function automatic logic [VW-1:0] pack(bit oe, bit byp, bit h, bit hb,
                                         bit m, bit mb, bit a, bit b);
    return {oe, byp, {NH{h}}, {NH{hb}}, m, mb, {N66{a}}, {N33{b}}};
  endfunction

  function automatic int flen(logic [2:0] c);
    return c[2] ? 8 : 12;   // R10 frame lengths
  endfunction

  // reference model: frame position, active code, run and enable flags
  int m_pos;
  logic [2:0] m_act;
  bit m_live, m_oe, m_byp, m_chg;

  task automatic push(logic [VW-1:0] v, string tag);
    item_t it;
    it.v = v;
    it.tag = tag;
    sb.push_back(it);
  endtask

  always @(posedge clk) begin
    bit h, m, a1, a2, b, slow;
    string tag;
    if (rst) begin
      m_act = sel; m_pos = flen(sel) - 1;
      m_live = 0; m_oe = 0; m_byp = 0; m_chg = 0;
      push('0, "R1 reset");
      push('0, "R1 reset");
    end else begin
      if (m_pos == flen(m_act) - 1) begin
        m_chg  = (sel != m_act);
        m_pos  = 0;
        m_act  = sel;
        m_oe   = (sel != 3'b011);
        m_live = m_oe && pwr_dn_n;
      end else begin
        m_pos++;
      end
      m_byp = (m_act == 3'b111);
      slow = !m_act[2];
      h = (m_pos % 2) == 0;
      m = ((m_pos / 2) % 2) == 0;
      if (slow) begin
        a1 = (m_pos % 3) != 2;
        a2 = (m_pos % 3) == 0;
        b  = (m_pos % 6) >= 1 && (m_pos % 6) <= 3;
      end else begin
        a1 = (m_pos % 4) < 2;
        a2 = a1;
        b  = (m_pos % 8) >= 1 && (m_pos % 8) <= 4;
      end
      if (!m_oe)         tag = "R8 hiz";
      else if (!m_live)  tag = "R11 stop";
      else if (m_byp)    tag = "R9 bypass R6";
      else if (slow)     tag = "R2 R3 R4 R5 R7 slow";
      else               tag = "R2 R3 R6 R7 fast";
      if (m_chg) tag = {"R10 switch ", tag};
      if (m_live) begin
        push(pack(m_oe, m_byp, h, !h, m, !m, a1, b), tag);
        push(pack(m_oe, m_byp, h, !h, m, !m, a2, b), tag);
      end else begin
        push(pack(m_oe, m_byp, 0, 0, 0, 0, 0, 0), tag);
        push(pack(m_oe, m_byp, 0, 0, 0, 0, 0, 0), tag);
      end
    end
  end

  task automatic compare();
    item_t it;
    logic [VW-1:0] got;
    got = {clk_oe, xtal_bypass, host_clk, host_clk_b, mem_ref, mem_ref_b, bus66, bus33};
    n_cmp++;
    if (sb.size() == 0) begin
      n_bad++;
      $display("FAIL R1 scoreboard empty: got %h exp queued item", got);
      return;
    end
    it = sb.pop_front();
    if (got !== it.v) begin
      n_bad++;
      $display("FAIL %s @%0t: got %h exp %h", it.tag, $time, got, it.v);
    end
  endtask

  // monitor: first half and second half of every cycle
  initial begin
    forever begin
      @(posedge clk);
      #1 compare();
      #2 compare();
    end
  end

  task automatic run(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  initial begin
    run(3);
    rst = 0;                     // R1 release with code 000
    run(30);
    sel = 3'b100;                // R10 mid-frame switch to fast family
    run(30);
    sel = 3'b111;                // R9 bypass
    run(30);
    sel = 3'b011;                // R8 high impedance
    run(30);
    sel = 3'b001;                // R4 R5 slow family again
    run(26);
    pwr_dn_n = 0;                // R11 stop
    run(30);
    pwr_dn_n = 1;
    run(30);
    sel = 3'b110;                // R6 fast family
    run(21);
    pwr_dn_n = 0;                // R11 short pulse inside a frame
    run(3);
    pwr_dn_n = 1;
    run(20);
    sel = 3'b010;                // R10 glitch shorter than a frame
    run(2);
    sel = 3'b110;
    run(20);
    sel = 3'b010;
    rst = 1;                     // R1 reset mid-run captures code 010
    run(2);
    rst = 0;
    run(40);
    done = 1;
    run(1);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #800000;
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL R1 watchdog: got running exp finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

endmodule